// File: doc/BRIEF.md
# Softmax Probability and Output-Error Unit

This block sits after the last fully connected layer of a small image classifier. It takes one frame of ten class scores, turns them into normalised probabilities, and names the winning class. When the frame is marked as a training frame, it also produces the output-error vector that backpropagation needs. Each error element is the probability minus the one-hot target for the supplied label. No logarithm or scalar loss value is produced.

Scores arrive as a beat stream while the unit is idle. The datapath then runs in four phases. First it scans the buffered scores for the largest one. Next it looks up a shifted exponential for every class and adds them into a running sum. It then divides each exponential by that sum in a bit-serial divider. Last, it streams ten results in class order and raises a completion pulse.

Scores are signed 16-bit values with 8 fraction bits. Probabilities are unsigned 16-bit values with 15 fraction bits, so 32768 stands for 1.0. Errors are signed 17-bit values on the same scale.

Top module: `smx_softmax_unit`

## Requirements
- R1: After reset, busy_o, out_valid_o and done_o are all low.
- R2: A score beat (in_valid_i high) is taken only while busy_o is low, and beats offered while busy_o is high are ignored. The frame is complete on the tenth taken beat, whether or not in_last_i is set on it. label_i and train_i are sampled together with that tenth beat.
- R3: If in_last_i is high on a taken beat before the tenth, the partial frame is discarded and produces no output. The next taken beat starts a new frame as class 0.
- R4: Let d be the largest score minus the score of class k, in units of 1/256, with d clamped to at most 7936 (31.0). The table offset is o = floor((d*5 + 128)/256), which lies in 0..155. The exponential e_k is round(32768 * exp(-o/5)), taken from a 156-entry table in which entry 155 is 1.0.
- R5: The probability of class k is floor(e_k * 32768 / S), where S is the sum of the ten e values. It never exceeds 32768.
- R6: pred_o gives the index of the largest score. On a tie, the lowest such index wins.
- R7: Ten result beats appear, one per out_valid_o pulse, in class order 0 to 9. out_class_o carries the class index, and out_last_o is high only on class 9.
- R8: In a training frame (train_i = 1), err_o is the probability minus 32768 for the class equal to the label, and the probability itself for every other class. A label of 10 to 15 matches no class.
- R9: In an inference frame (train_i = 0), err_o is zero on every result beat.
- R10: done_o is high for exactly one cycle: the cycle right after the beat that carries out_last_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Score beat present |
| in_last_i | input | 1 | Frame end marker; when seen early it discards the partial frame |
| score_i | input | 16 | Class score, signed, 8 fraction bits |
| label_i | input | 4 | Target class index for training |
| train_i | input | 1 | 1 selects training (error output), 0 selects inference |
| busy_o | output | 1 | Frame being processed; input beats ignored |
| out_valid_o | output | 1 | Result beat present |
| out_last_o | output | 1 | Result beat is class 9 |
| out_class_o | output | 4 | Class index of the result beat |
| prob_o | output | 16 | Probability, unsigned, 15 fraction bits |
| err_o | output | 17 | Output error, signed, 15 fraction bits |
| pred_o | output | 4 | Predicted class |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two events can share a cycle. The completion pulse of one frame is in the same cycle as the first score beat of the next frame, because busy_o falls in the cycle where done_o rises. The bench provokes this by feeding frames back to back: each new frame is driven as soon as busy_o is seen low. The bench then judges that the done pulse still lands one cycle after the last result beat. It also judges that the following frame's ten results all match the expected values, which shows the overlapping beat was taken as class 0. Beats pushed while busy_o is high and a frame cut short by an early end marker must leave the output stream unchanged.

// File: rtl/smx_pkg.sv
package smx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MAX,
    ST_EXP,
    ST_DIV,
    ST_FIN
  } smx_state_e;

  // table entry idx of depth entries, spanning exp(-span)..exp(0), scaled by 2^frac
  function automatic int exp_code(int idx, int depth, int span, int frac);
    real arg;
    arg = -real'(span) * real'(depth - 1 - idx) / real'(depth - 1);
    return $rtoi($exp(arg) * real'(1 << frac) + 0.5);
  endfunction

endpackage

// File: rtl/smx_score_rf.sv
module smx_score_rf #(
  parameter int unsigned N_CLASS = 10,
  parameter int unsigned SCORE_W = 16,
  parameter int unsigned IDX_W   = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      accept_i,
  input  logic                      valid_i,
  input  logic                      last_i,
  input  logic signed [SCORE_W-1:0] score_i,
  input  logic [IDX_W-1:0]          rd_idx_i,
  output logic signed [SCORE_W-1:0] rd_score_o,
  output logic                      frame_full_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_CLASS - 1);

  logic signed [SCORE_W-1:0] rf_q [N_CLASS];
  logic [IDX_W-1:0]          ptr_q;
  logic                      take;

  assign take         = accept_i && valid_i;
  assign frame_full_o = take && (ptr_q == LAST_IDX);
  assign rd_score_o   = rf_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      for (int i = 0; i < int'(N_CLASS); i++) rf_q[i] <= '0;
    end else if (take) begin
      rf_q[ptr_q] <= score_i;
      if (ptr_q == LAST_IDX || last_i) ptr_q <= '0;
      else                             ptr_q <= ptr_q + 1'b1;
    end
  end

  AST_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= LAST_IDX) else $error("write pointer out of range"); // R2

  AST_PTR_HOLD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> $stable(ptr_q)) else $error("pointer moved while busy"); // R2

endmodule

// File: rtl/smx_exp_lut.sv
module smx_exp_lut #(
  parameter int unsigned SCORE_FRAC = 8,
  parameter int unsigned DEPTH      = 156,
  parameter int unsigned SPAN       = 31,
  parameter int unsigned EXP_FRAC   = 15,
  parameter int unsigned DIFF_W     = 17,
  localparam int unsigned EXP_W     = EXP_FRAC + 1
) (
  input  logic [DIFF_W-1:0] mag_i,
  output logic [EXP_W-1:0]  exp_o
);

  localparam int unsigned     IDX_W   = $clog2(DEPTH);
  localparam logic [31:0]     STEPS   = 32'(DEPTH - 1);
  localparam logic [31:0]     MAG_MAX = 32'(SPAN << SCORE_FRAC);

  logic [EXP_W-1:0] tbl [DEPTH];
  logic [31:0]      mag_c, off_c;
  logic [IDX_W-1:0] idx_c;

  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_tbl
    assign tbl[g] = EXP_W'(smx_pkg::exp_code(g, int'(DEPTH), int'(SPAN), int'(EXP_FRAC)));
  end

  always_comb begin
    mag_c = (32'(mag_i) > MAG_MAX) ? MAG_MAX : 32'(mag_i);
    off_c = (mag_c * STEPS + (MAG_MAX >> 1)) / MAG_MAX;  // round to nearest step
    idx_c = IDX_W'(STEPS - off_c);
    exp_o = tbl[idx_c];
  end

endmodule

// File: rtl/smx_seq_div.sv
module smx_seq_div #(
  parameter int unsigned NUM_W = 16,
  parameter int unsigned DEN_W = 19,
  parameter int unsigned Q_W   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [Q_W-1:0]   quot_o
);

  localparam int unsigned REM_W = DEN_W + 1;
  localparam int unsigned CNT_W = $clog2(Q_W);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(Q_W - 1);

  logic [REM_W-1:0] rem_q, rem_sub;
  logic [DEN_W-1:0] den_q;
  logic [Q_W-1:0]   quot_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q, bit_c;

  // quotient bit weights run from 2^(Q_W-1) down to 2^0
  assign bit_c   = rem_q >= {1'b0, den_q};
  assign rem_sub = bit_c ? rem_q - {1'b0, den_q} : rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      den_q  <= '0;
      quot_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        rem_q  <= REM_W'(num_i);
        den_q  <= den_i;
        quot_q <= '0;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q  <= {rem_sub[REM_W-2:0], 1'b0};
        quot_q <= {quot_q[Q_W-2:0], bit_c};
        cnt_q  <= cnt_q + 1'b1;
        if (cnt_q == LAST_STEP) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = quot_q;

  AST_DIV_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q) else $error("divider restarted while busy"); // R5

  AST_DIV_NUM_LE_DEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (DEN_W'(num_i) <= den_i)) else $error("numerator above sum"); // R5

  AST_DIV_QUOT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (quot_o <= Q_W'(1 << (Q_W - 1)))) else $error("probability above one"); // R5

endmodule

// File: rtl/smx_softmax_unit.sv
module smx_softmax_unit #(
  parameter int unsigned N_CLASS    = 10,
  parameter int unsigned SCORE_W    = 16,
  parameter int unsigned SCORE_FRAC = 8,
  parameter int unsigned LUT_DEPTH  = 156,
  parameter int unsigned LUT_SPAN   = 31,
  parameter int unsigned PROB_FRAC  = 15,
  localparam int unsigned CLS_W     = $clog2(N_CLASS),
  localparam int unsigned PROB_W    = PROB_FRAC + 1,
  localparam int unsigned ERR_W     = PROB_W + 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      in_valid_i,
  input  logic                      in_last_i,
  input  logic [SCORE_W-1:0]        score_i,
  input  logic [CLS_W-1:0]          label_i,
  input  logic                      train_i,
  output logic                      busy_o,
  output logic                      out_valid_o,
  output logic                      out_last_o,
  output logic [CLS_W-1:0]          out_class_o,
  output logic [PROB_W-1:0]         prob_o,
  output logic signed [ERR_W-1:0]   err_o,
  output logic [CLS_W-1:0]          pred_o,
  output logic                      done_o
);

  import smx_pkg::*;

  localparam int unsigned SUM_W  = $clog2(N_CLASS * (2 ** PROB_FRAC) + 1);
  localparam int unsigned DIFF_W = SCORE_W + 1;
  localparam logic [CLS_W-1:0]        LAST_CLS = CLS_W'(N_CLASS - 1);
  localparam logic signed [ERR_W-1:0] ONE_ERR  = ERR_W'(2 ** PROB_FRAC);

  smx_state_e state_q;
  logic [CLS_W-1:0]          idx_q, pred_q, label_q, cls_q;
  logic signed [SCORE_W-1:0] max_q, rd_score;
  logic [SUM_W-1:0]          sum_q;
  logic [PROB_W-1:0]         exp_rf_q [N_CLASS];
  logic [PROB_W-1:0]         prob_q, lut_exp, div_quot;
  logic signed [ERR_W-1:0]   err_q, prob_ext, err_c;
  logic                      train_q, start_q, out_valid_q, out_last_q, done_q;
  logic                      frame_full, div_done;
  logic signed [DIFF_W-1:0]  diff_c;

  smx_score_rf #(
    .N_CLASS (N_CLASS),
    .SCORE_W (SCORE_W),
    .IDX_W   (CLS_W)
  ) u_score_rf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .accept_i     (state_q == ST_IDLE),
    .valid_i      (in_valid_i),
    .last_i       (in_last_i),
    .score_i      (score_i),
    .rd_idx_i     (idx_q),
    .rd_score_o   (rd_score),
    .frame_full_o (frame_full)
  );

  assign diff_c = DIFF_W'(max_q) - DIFF_W'(rd_score);

  smx_exp_lut #(
    .SCORE_FRAC (SCORE_FRAC),
    .DEPTH      (LUT_DEPTH),
    .SPAN       (LUT_SPAN),
    .EXP_FRAC   (PROB_FRAC),
    .DIFF_W     (DIFF_W)
  ) u_exp_lut (
    .mag_i (diff_c),
    .exp_o (lut_exp)
  );

  smx_seq_div #(
    .NUM_W (PROB_W),
    .DEN_W (SUM_W),
    .Q_W   (PROB_W)
  ) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_q),
    .num_i   (exp_rf_q[idx_q]),
    .den_i   (sum_q),
    .done_o  (div_done),
    .quot_o  (div_quot)
  );

  assign prob_ext = $signed({1'b0, div_quot});
  assign err_c    = !train_q ? '0 :
                    (idx_q == label_q) ? prob_ext - ONE_ERR : prob_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      pred_q      <= '0;
      label_q     <= '0;
      train_q     <= 1'b0;
      max_q       <= '0;
      sum_q       <= '0;
      start_q     <= 1'b0;
      out_valid_q <= 1'b0;
      out_last_q  <= 1'b0;
      cls_q       <= '0;
      prob_q      <= '0;
      err_q       <= '0;
      done_q      <= 1'b0;
      for (int i = 0; i < int'(N_CLASS); i++) exp_rf_q[i] <= '0;
    end else begin
      start_q     <= 1'b0;
      out_valid_q <= 1'b0;
      done_q      <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (frame_full) begin
          state_q <= ST_MAX;
          idx_q   <= '0;
          label_q <= label_i;
          train_q <= train_i;
        end
        ST_MAX: begin
          // strict compare keeps the lowest index on ties
          if (idx_q == '0 || rd_score > max_q) begin
            max_q  <= rd_score;
            pred_q <= idx_q;
          end
          if (idx_q == LAST_CLS) begin
            state_q <= ST_EXP;
            idx_q   <= '0;
            sum_q   <= '0;
          end else idx_q <= idx_q + 1'b1;
        end
        ST_EXP: begin
          exp_rf_q[idx_q] <= lut_exp;
          sum_q           <= sum_q + SUM_W'(lut_exp);
          if (idx_q == LAST_CLS) begin
            state_q <= ST_DIV;
            idx_q   <= '0;
            start_q <= 1'b1;
          end else idx_q <= idx_q + 1'b1;
        end
        ST_DIV: if (div_done) begin
          out_valid_q <= 1'b1;
          out_last_q  <= (idx_q == LAST_CLS);
          cls_q       <= idx_q;
          prob_q      <= div_quot;
          err_q       <= err_c;
          if (idx_q == LAST_CLS) state_q <= ST_FIN;
          else begin
            idx_q   <= idx_q + 1'b1;
            start_q <= 1'b1;
          end
        end
        ST_FIN: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign out_valid_o = out_valid_q;
  assign out_last_o  = out_last_q;
  assign out_class_o = cls_q;
  assign prob_o      = prob_q;
  assign err_o       = err_q;
  assign pred_o      = pred_q;
  assign done_o      = done_q;

  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_last_o |=> done_o) else $error("done not after last beat"); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o) else $error("done wider than one cycle"); // R10

  AST_INFER_ERR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !train_q |-> err_o == '0) else $error("inference error nonzero"); // R9

  AST_LAST_IS_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_last_o |-> out_class_o == LAST_CLS) else $error("last on wrong class"); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !out_valid_o) else $error("result beat while idle"); // R7

  AST_SUM_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> sum_q != '0) else $error("zero exponential sum"); // R5

endmodule

// File: tb/smx_softmax_unit_tb.sv
`timescale 1ns/1ps
module smx_softmax_unit_tb_top;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               in_valid_i = 1'b0;
  logic               in_last_i = 1'b0;
  logic [15:0]        score_i = '0;
  logic [3:0]         label_i = '0;
  logic               train_i = 1'b0;
  logic               busy_o, out_valid_o, out_last_o, done_o;
  logic [3:0]         out_class_o, pred_o;
  logic [15:0]        prob_o;
  logic signed [16:0] err_o;

  int n_checks = 0;
  int n_fails  = 0;
  int q_cls[$], q_prob[$], q_err[$], q_pred[$], q_train[$];
  bit prev_last = 1'b0;

  always #4 clk_i = ~clk_i;

  smx_softmax_unit dut_i (
    .clk_i, .rst_ni, .in_valid_i, .in_last_i, .score_i, .label_i, .train_i,
    .busy_o, .out_valid_o, .out_last_o, .out_class_o, .prob_o, .err_o,
    .pred_o, .done_o
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int lut_val(int off);
    return $rtoi($exp(-real'(off) / 5.0) * 32768.0 + 0.5);
  endfunction

  // driver: computes expected items (R4,R5,R6,R8,R9), pushes them, then drives beats
  task automatic send_frame(input int sc[10], input int label, input bit train);
    int mx, pd, d, s;
    int e[10];
    longint p;
    mx = sc[0]; pd = 0;
    for (int i = 1; i < 10; i++) if (sc[i] > mx) begin mx = sc[i]; pd = i; end
    s = 0;
    for (int i = 0; i < 10; i++) begin
      d = mx - sc[i];
      if (d > 7936) d = 7936;
      e[i] = lut_val((d * 5 + 128) / 256);
      s += e[i];
    end
    for (int i = 0; i < 10; i++) begin
      p = (longint'(e[i]) * 32768) / s;
      q_cls.push_back(i);
      q_prob.push_back(int'(p));
      q_err.push_back(!train ? 0 : (i == label) ? int'(p) - 32768 : int'(p));
      q_pred.push_back(pd);
      q_train.push_back(int'(train));
    end
    while (busy_o) @(negedge clk_i);
    for (int i = 0; i < 10; i++) begin
      in_valid_i = 1'b1;
      score_i    = sc[i][15:0];
      in_last_i  = (i == 9);
      label_i    = label[3:0];
      train_i    = train;
      @(negedge clk_i);
    end
    in_valid_i = 1'b0;
    in_last_i  = 1'b0;
  endtask

  task automatic send_short(input int n);
    while (busy_o) @(negedge clk_i);
    for (int i = 0; i < n; i++) begin
      in_valid_i = 1'b1;
      score_i    = 16'(1000 * (i + 1));
      in_last_i  = (i == n - 1);
      @(negedge clk_i);
    end
    in_valid_i = 1'b0;
    in_last_i  = 1'b0;
  endtask

  task automatic poke_busy();
    for (int i = 0; i < 10; i++) begin
      check(busy_o == 1'b1, "R2 busy during junk", int'(busy_o), 1);
      in_valid_i = 1'b1;
      score_i    = 16'(20000 - 3000 * i);
      in_last_i  = (i == 9);
      @(negedge clk_i);
    end
    in_valid_i = 1'b0;
    in_last_i  = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (prev_last) check(done_o == 1'b1, "R10 done after last", int'(done_o), 1);
      else if (done_o) check(1'b0, "R10 stray done", 1, 0);
      prev_last = out_valid_o && out_last_o;
      if (out_valid_o) begin
        if (q_cls.size() == 0) begin
          check(1'b0, "R2/R3 unexpected result beat", int'(out_class_o), -1);
        end else begin
          int c, p, e, pd, t;
          c = q_cls.pop_front(); p = q_prob.pop_front(); e = q_err.pop_front();
          pd = q_pred.pop_front(); t = q_train.pop_front();
          check(int'(out_class_o) == c, "R7 class order", int'(out_class_o), c);
          check(out_last_o == (c == 9), "R7 last flag", int'(out_last_o), int'(c == 9));
          check(int'(prob_o) == p, "R4/R5 probability", int'(prob_o), p);
          if (t != 0) check(int'(err_o) == e, "R8 training error", int'(err_o), e);
          else        check(int'(err_o) == 0, "R9 inference error", int'(err_o), 0);
          check(int'(pred_o) == pd, "R6 predicted class", int'(pred_o), pd);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk_i);
    check(1'b0, "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    int f_eq[10]   = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    int f_dom[10]  = '{0, 0, 0, 0, 0, 0, 0, 10240, 0, 0};
    int f_tie[10]  = '{100, -50, 512, 0, 300, 512, 10, -700, 200, 511};
    int f_ramp[10];
    int f_mix[10]  = '{-32768, 32767, 0, 24831, 24767, -256, 1000, 32000, 31000, -1};
    int f_near[10] = '{256, 192, 128, 64, 0, -64, -128, -192, -256, 300};
    for (int i = 0; i < 10; i++) f_ramp[i] = i * 64 - 300;

    repeat (3) @(negedge clk_i);
    // R1: state during and right after reset
    check(busy_o == 1'b0, "R1 busy at reset", int'(busy_o), 0);
    check(out_valid_o == 1'b0, "R1 out_valid at reset", int'(out_valid_o), 0);
    check(done_o == 1'b0, "R1 done at reset", int'(done_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(busy_o == 1'b0, "R1 busy after reset", int'(busy_o), 0);

    send_frame(f_eq, 3, 1'b1);       // uniform: each 3276
    send_frame(f_dom, 7, 1'b1);      // far-apart scores clamp, R4
    send_frame(f_tie, 5, 1'b0);      // tie, lowest index wins, R6, R9
    send_frame(f_ramp, 12, 1'b1);    // label out of range, R8
    poke_busy();                     // R2: ignored beats
    send_short(5);                   // R3: discarded frame
    send_frame(f_mix, 0, 1'b1);      // extremes, R4 clamp
    send_frame(f_near, 9, 1'b1);     // back to back with done overlap
    send_frame(f_eq, 9, 1'b0);

    while (busy_o || q_cls.size() != 0) @(negedge clk_i);
    repeat (40) @(negedge clk_i);
    check(q_cls.size() == 0, "R7 all results seen", q_cls.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule